// File: doc/BRIEF.md
# Numerically Controlled PWM Generator with Deferred Settings Update

This block produces one pulse-width-modulated output from a fixed reference clock. The period comes from a phase accumulator. On every reference cycle the accumulator adds a programmable step, called the rate step. The duty cycle comes from comparing the accumulator's most significant byte with an 8-bit threshold. The threshold is coded inversely: a larger value gives a shorter high time.

Software sees a single 32-bit control word at offset 0. Writes land in shadow fields. The running generator uses a separate active copy. The shadow values move into the active copy only after software sets a self-clearing update request. While the generator runs, the copy waits for the next accumulator wrap, so a period is never cut short. The enable bit only takes effect once at least one such copy has completed since reset.

Top module: `nco_pwm`

## Requirements
- R1: While reset is asserted and right after it is released, the output is low and the control word reads back as all zeros.
- R2: A write at offset 0 stores the enable bit (bit 31), the rate step (bits 8 upward, RATE_W bits wide) and the threshold (bits 7:0). A read at offset 0 returns them in the same positions, and every unused bit reads 0. A write at any other offset changes nothing and does not alter the output.
- R3: A write with bit 30 set makes bit 30 read 1 from the next cycle. Bit 30 clears itself in the cycle after the shadow fields have been copied into the active fields. A new request made in the same cycle as a copy keeps it at 1.
- R4: Until a first copy has completed since reset, the output stays low whatever the enable bit holds.
- R5: While the generator is running (enable set and a copy seen), the accumulator, RATE_W bits wide, adds the active rate step each cycle modulo 2^RATE_W. The output is high exactly when the accumulator's top byte is strictly greater than the active threshold. A period therefore lasts 2^RATE_W / step cycles.
- R6: While the generator is running, new shadow values do not affect the output until a copy occurs. A pending copy fires only on a cycle where the accumulator carries out of its top bit, or where the active step is 0. When the generator is not running, a pending copy fires on the next cycle.
- R7: Clearing the enable bit drives the output low from the next cycle and holds the accumulator at zero. Setting it again restarts counting from zero with the last copied values, and no new update request is needed.
- R8: An active rate step of 0 freezes the accumulator, so the output holds a constant level.
- R9: Over a whole number of periods, the output is high in a fraction of cycles set by the threshold. With a step of 1/16 of full scale, thresholds 0x00, 0x7F and 0xFF give 15, 8 and 0 high cycles per 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| reg_addr | input | ADDR_W | Byte offset within the channel window; only 0 is decoded |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong active copy or a copy at the wrong moment shows on pwm_out within one period. The bench's cycle-by-cycle model counts high cycles, so such an error appears as a shifted edge or a wrong duty count. A stuck or early-clearing pending flag shows on bit 30 of the read word on the next cycle. A missing restart from zero after enable shows in the first two output cycles after enable, when a zero threshold must give low and then high. Corrupted accumulator state shows as a wrong period within one wrap.

// File: rtl/nco_pwm_pkg.sv
package nco_pwm_pkg;
  localparam int CTL_EN_BIT  = 31;
  localparam int CTL_UPD_BIT = 30;
  localparam int THR_W       = 8;
  localparam int STEP_LSB    = 8;
  localparam int WORD_W      = 32;
endpackage

// File: rtl/nco_pwm_regs.sv
module nco_pwm_regs
  import nco_pwm_pkg::*;
#(
  parameter int RATE_W = 22,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              xfer_fire,
  output logic              sh_en,
  output logic [RATE_W-1:0] sh_step,
  output logic [THR_W-1:0]  sh_thr,
  output logic              pend,
  output logic              upd_req,
  output logic [WORD_W-1:0] rd_data
);
  logic addr_hit;
  logic wr_hit;

  assign addr_hit = (reg_addr == '0);
  assign wr_hit   = wr_en && addr_hit;
  assign upd_req  = wr_hit && wr_data[CTL_UPD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en   <= 1'b0;
      sh_step <= '0;
      sh_thr  <= '0;
    end else if (wr_hit) begin
      sh_en   <= wr_data[CTL_EN_BIT];
      sh_step <= wr_data[STEP_LSB +: RATE_W];
      sh_thr  <= wr_data[THR_W-1:0];
    end
  end

  // a fresh request outranks the clear caused by a copy in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend <= 1'b0;
    else if (upd_req)   pend <= 1'b1;
    else if (xfer_fire) pend <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (addr_hit) begin
      rd_data[CTL_EN_BIT]            = sh_en;
      rd_data[CTL_UPD_BIT]           = pend;
      rd_data[STEP_LSB +: RATE_W]    = sh_step;
      rd_data[THR_W-1:0]             = sh_thr;
    end
  end
endmodule

// File: rtl/nco_pwm_xfer.sv
module nco_pwm_xfer
  import nco_pwm_pkg::*;
#(
  parameter int RATE_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic              sh_en,
  input  logic [RATE_W-1:0] sh_step,
  input  logic [THR_W-1:0]  sh_thr,
  input  logic              acc_wrap,
  output logic [RATE_W-1:0] act_step,
  output logic [THR_W-1:0]  act_thr,
  output logic              upd_seen,
  output logic              gen_run,
  output logic              xfer_fire
);
  logic boundary;

  assign gen_run   = sh_en && upd_seen;
  assign boundary  = acc_wrap || (act_step == '0);
  assign xfer_fire = pend && (!gen_run || boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_step <= '0;
      act_thr  <= '0;
      upd_seen <= 1'b0;
    end else if (xfer_fire) begin
      act_step <= sh_step;
      act_thr  <= sh_thr;
      upd_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/nco_pwm_core.sv
module nco_pwm_core
  import nco_pwm_pkg::*;
#(
  parameter int RATE_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_run,
  input  logic [RATE_W-1:0] act_step,
  input  logic [THR_W-1:0]  act_thr,
  output logic [RATE_W-1:0] acc,
  output logic              acc_wrap,
  output logic              pwm_out
);
  localparam int TOP_LSB = RATE_W - THR_W;

  function automatic logic [RATE_W:0] phase_sum(input logic [RATE_W-1:0] a,
                                                input logic [RATE_W-1:0] s);
    return {1'b0, a} + {1'b0, s};
  endfunction

  function automatic logic above_thr(input logic [RATE_W-1:0] a,
                                     input logic [THR_W-1:0] t);
    return a[TOP_LSB +: THR_W] > t;
  endfunction

  logic [RATE_W:0] sum;

  assign sum      = phase_sum(acc, act_step);
  assign acc_wrap = gen_run && sum[RATE_W];
  assign pwm_out  = gen_run && above_thr(acc, act_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (gen_run) acc <= sum[RATE_W-1:0];
    else              acc <= '0;
  end
endmodule

// File: rtl/nco_pwm.sv
module nco_pwm
  import nco_pwm_pkg::*;
#(
  parameter int RATE_W = 22,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              pwm_out
);
  logic              sh_en;
  logic [RATE_W-1:0] sh_step;
  logic [THR_W-1:0]  sh_thr;
  logic              pend;
  logic              upd_req;
  logic [RATE_W-1:0] act_step;
  logic [THR_W-1:0]  act_thr;
  logic              upd_seen;
  logic              gen_run;
  logic              xfer_fire;
  logic [RATE_W-1:0] acc;
  logic              acc_wrap;

  nco_pwm_regs #(.RATE_W(RATE_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .xfer_fire(xfer_fire), .sh_en(sh_en),
    .sh_step(sh_step), .sh_thr(sh_thr), .pend(pend), .upd_req(upd_req),
    .rd_data(rd_data)
  );

  nco_pwm_xfer #(.RATE_W(RATE_W)) xfer_i (
    .clk(clk), .rst_n(rst_n), .pend(pend), .sh_en(sh_en),
    .sh_step(sh_step), .sh_thr(sh_thr), .acc_wrap(acc_wrap),
    .act_step(act_step), .act_thr(act_thr), .upd_seen(upd_seen),
    .gen_run(gen_run), .xfer_fire(xfer_fire)
  );

  nco_pwm_core #(.RATE_W(RATE_W)) core_i (
    .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .act_step(act_step),
    .act_thr(act_thr), .acc(acc), .acc_wrap(acc_wrap), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/nco_pwm_chk.sv
module nco_pwm_chk #(
  parameter int RATE_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_out,
  input logic              sh_en,
  input logic              pend,
  input logic              upd_req,
  input logic              upd_seen,
  input logic              gen_run,
  input logic              xfer_fire,
  input logic              acc_wrap,
  input logic [RATE_W-1:0] act_step,
  input logic [7:0]        act_thr,
  input logic [RATE_W-1:0] acc
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_low_in_reset: assert (!pwm_out);
    end
  end

  a_r3_req_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> pend);

  a_r3_copy_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && !upd_req) |=> !pend);

  a_r4_silent_before_copy: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_seen |-> !pwm_out);

  a_r5_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    gen_run |=> (acc == RATE_W'($past(acc) + $past(act_step))));

  a_r6_copy_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && gen_run) |-> (acc_wrap || act_step == '0));

  a_r6_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_fire |=> ($stable(act_step) && $stable(act_thr)));

  a_r7_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_en |-> !pwm_out);

  a_r7_off_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_run |=> (acc == '0));

  a_r8_frozen_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_run && act_step == '0 && !xfer_fire) |=> $stable(acc));
endmodule

bind nco_pwm nco_pwm_chk #(.RATE_W(RATE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .sh_en(sh_en), .pend(pend),
  .upd_req(upd_req), .upd_seen(upd_seen), .gen_run(gen_run),
  .xfer_fire(xfer_fire), .acc_wrap(acc_wrap), .act_step(act_step),
  .act_thr(act_thr), .acc(acc)
);

// File: tb/nco_pwm_tb.sv
module nco_pwm_tb_top;
  localparam int W  = 22;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          pwm_out;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nco_pwm #(.RATE_W(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // ---- reference model written from the requirements ----
  function automatic logic [31:0] word(input bit en, input bit upd,
                                       input logic [W-1:0] step, input logic [7:0] thr);
    logic [31:0] v;
    v = {en, upd, 30'd0};
    v = v | ({10'd0, step} << 8) | {24'd0, thr};
    return v;
  endfunction

  function automatic bit high_for(input logic [W-1:0] a, input logic [7:0] t);
    return (a >> (W - 8)) > {{(W-8){1'b0}}, t};
  endfunction

  logic          m_en, m_pend, m_seen;
  logic [W-1:0]  m_sstep, m_astep, m_acc;
  logic [7:0]    m_sthr, m_athr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_pend <= 0; m_seen <= 0;
      m_sstep <= 0; m_astep <= 0; m_acc <= 0; m_sthr <= 0; m_athr <= 0;
    end else begin
      bit run, fire, carry, hit;
      logic [W:0] s;
      run   = m_en && m_seen;
      s     = {1'b0, m_acc} + {1'b0, m_astep};
      carry = s[W];
      fire  = m_pend && (!run || m_astep == 0 || carry);
      hit   = wr_en && reg_addr == 0;
      if (hit) begin
        m_en <= wr_data[31]; m_sstep <= wr_data[8 +: W]; m_sthr <= wr_data[7:0];
      end
      if (hit && wr_data[30]) m_pend <= 1;
      else if (fire)          m_pend <= 0;
      if (fire) begin
        m_astep <= m_sstep; m_athr <= m_sthr; m_seen <= 1;
      end
      m_acc <= run ? s[W-1:0] : '0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // continuous comparison against the model, half a cycle from the edge (R5, R6, R2)
  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      bit eo;
      logic [31:0] er;
      eo = m_en && m_seen && high_for(m_acc, m_athr);
      check(pwm_out === eo, "R5 output vs model", {31'd0, pwm_out}, {31'd0, eo});
      er = (reg_addr == 0) ? word(m_en, m_pend, m_sstep, m_sthr) : 32'd0;
      check(rd_data === er, "R2 readback vs model", rd_data, er);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; reg_addr = 0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      if (pwm_out) hi++;
    end
  endtask

  task automatic wait_copy();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #2;
      if (!rd_data[30]) break;
    end
  endtask

  localparam logic [W-1:0] STEP16 = W'(1) << (W - 4);

  initial begin
    #(8 * 200000);
    n_run++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int hi;
    bit first, same;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(pwm_out === 1'b0, "R1 out low in reset", {31'd0, pwm_out}, 0);
    rst_n = 1;
    @(negedge clk); settle();
    check(rd_data === 32'd0, "R1 word zero after reset", rd_data, 0);

    // R4: enable without any copy
    wr(0, word(1, 0, STEP16, 8'h7F));
    settle();
    check(rd_data === 32'h8400007F, "R2 fields readback", rd_data, 32'h8400007F);
    count_high(100, hi);
    check(hi == 0, "R4 no output before copy", hi, 0);

    // R3: request then self-clear
    wr(0, word(1, 1, STEP16, 8'h7F));
    settle();
    check(rd_data[30] === 1'b1, "R3 pending reads 1", {31'd0, rd_data[30]}, 1);
    @(negedge clk); settle();
    check(rd_data[30] === 1'b0, "R3 pending self-clears", {31'd0, rd_data[30]}, 0);

    // R9 duty counts
    count_high(32, hi);
    check(hi == 16, "R9 duty thr 0x7F", hi, 16);

    // R6: shadow change without request has no effect
    wr(0, word(1, 0, STEP16, 8'hFF));
    count_high(32, hi);
    check(hi == 16, "R6 unchanged before copy", hi, 16);
    wr(0, word(1, 1, STEP16, 8'hFF));
    settle();
    check(rd_data[30] === 1'b1, "R3 pending while running", {31'd0, rd_data[30]}, 1);
    wait_copy();
    count_high(32, hi);
    check(hi == 0, "R9 duty thr 0xFF", hi, 0);

    wr(0, word(1, 1, STEP16, 8'h00));
    wait_copy();
    count_high(32, hi);
    check(hi == 30, "R9 duty thr 0x00", hi, 30);

    // R7: disable and restart from zero
    wr(0, word(0, 0, STEP16, 8'h00));
    settle();
    check(pwm_out === 1'b0, "R7 low after disable", {31'd0, pwm_out}, 0);
    count_high(20, hi);
    check(hi == 0, "R7 stays low while disabled", hi, 0);
    wr(0, word(1, 0, STEP16, 8'h00));
    settle();
    check(pwm_out === 1'b0, "R7 restart at zero low", {31'd0, pwm_out}, 0);
    @(negedge clk); settle();
    check(pwm_out === 1'b1, "R7 second cycle high", {31'd0, pwm_out}, 1);

    // R8: zero step freezes level
    wr(0, word(1, 1, '0, 8'h00));
    wait_copy();
    @(negedge clk); settle();
    first = pwm_out; same = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); settle();
      if (pwm_out !== first) same = 0;
    end
    check(same, "R8 constant level with zero step", {31'd0, same}, 1);

    // R2: other offset ignored
    wr(10'h004, 32'hFFFF_FFFF);
    settle();
    check(rd_data === 32'h8000_0000, "R2 other offset ignored", rd_data, 32'h8000_0000);
    check(pwm_out === first, "R2 output untouched", {31'd0, pwm_out}, {31'd0, first});

    // random phase, checked every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 8) == 0) begin
        logic [W-1:0] st;
        case ($urandom % 4)
          0: st = STEP16;
          1: st = W'($urandom) & (W'(-1) << (W - 6));
          2: st = '0;
          default: st = W'($urandom);
        endcase
        wr_en = 1;
        reg_addr = (($urandom % 6) == 0) ? 10'h008 : 10'h000;
        wr_data = word(($urandom % 5) != 0, ($urandom % 2) == 1, st, 8'($urandom));
      end else begin
        wr_en = 0; reg_addr = 0;
      end
    end
    @(negedge clk);
    wr_en = 0; reg_addr = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule